// File: doc/BRIEF.md
# Back-EMF Zero-Crossing Commutation Scheduler

This block sits between the converter that samples the unpowered motor phase and the six-step switch pattern logic of a sensorless brushless DC drive. Each valid sample pairs a signed phase voltage with the DC-bus voltage. After a commutation, the block first waits for the winding current to decay. It then watches the sign of the phase voltage measured against half the bus voltage. When that sign flips, it records the timer count at that sample. It places the next commutation half a commutation period later, because at steady speed the crossing falls midway between two commutations.

A prescaled commutation timer counts ticks from the last commutation. It raises a one-cycle trigger when the count reaches the loaded limit, and it reports the length of the interval that just ended. A running sum of the last six intervals gives the period of one electrical revolution. If no crossing turns up, the timer falls back to a timeout of twice the last period and flags the missed crossing. The block also works out the next sector in the chosen rotation direction and the converter input that faces the unpowered phase. It also computes how far into the PWM period the converter should sample: two fifths of the duty count, but never less than a programmable floor.

Top module: `bemf_comm_sched`

## Requirements
- R1: The back-EMF sign is taken from 2*phase_smp - bus_smp, which is the phase voltage against half the bus voltage with no rounding. A result of zero counts as non-negative. A crossing is a change of sign between two consecutive accepted samples, in either direction.
- R2: A sample is accepted only while the tick count since the last commutation is at least DECAY_TICKS. Earlier samples are ignored. The first accepted sample in an interval serves only as the sign reference.
- R3: After the first crossing in an interval, later samples are ignored until the next commutation.
- R4: A crossing takes as its stamp the tick count of its sample. The next commutation then falls stamp + max(P/2, 1) ticks after the last one, where P is the current period_out. That commutation carries missed_zc = 0.
- R5: If an interval has no crossing, the commutation falls 2*P ticks after the last one, saturated at the timer maximum. missed_zc is high in that commutation's pulse cycle and at no other time.
- R6: The timer advances once every TICK_DIV clock cycles. comm_pulse is high for one cycle per commutation. period_out takes the length of the finished interval in ticks and changes only at a commutation.
- R7: A sample that arrives in the cycle of comm_pulse is discarded. The new interval starts with no sign reference.
- R8: For sectors 0 to 5, next_sector is sector+1 modulo 6 when dir_fwd = 1, and sector-1 modulo 6 when dir_fwd = 0.
- R9: adc_sel gives the unpowered phase with the encoding A = 0, B = 1, C = 2. Sectors 0 and 3 select C, sectors 1 and 4 select B, and sectors 2 and 5 select A.
- R10: smp_delay = max(floor(2*duty/5), dly_min).
- R11: rev_sum is the sum of the last six period_out values and is updated at each commutation.
- R12: After reset, period_out = INIT_PERIOD, rev_sum = 6*INIT_PERIOD, and the first commutation comes 2*INIT_PERIOD ticks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe for phase_smp and bus_smp |
| phase_smp | input | SW | Signed voltage of the unpowered phase |
| bus_smp | input | SW | Unsigned DC-bus voltage |
| sector | input | 3 | Current commutation sector, 0 to 5 |
| dir_fwd | input | 1 | Rotation direction, 1 counts sectors upward |
| duty | input | DW | PWM duty count |
| dly_min | input | DW | Lower limit of the sample delay |
| comm_pulse | output | 1 | One-cycle commutation trigger |
| next_sector | output | 3 | Sector to apply at the next commutation |
| adc_sel | output | 2 | Converter input for the unpowered phase |
| period_out | output | TW | Length of the last commutation interval in ticks |
| rev_sum | output | TW+3 | Sum of the last six intervals |
| missed_zc | output | 1 | Commutation reached without a crossing |
| smp_delay | output | DW | Sample delay after the PWM period start |

## Verification
A sign flip can reach the detector in the very clock cycle in which the timer reaches its limit and fires the commutation. The bench provokes this by setting a sign reference partway through a timeout interval. It then waits until comm_pulse is high and presents a sample of the opposite sign in that same cycle. The outcome is judged only at the ports. missed_zc must be high in that pulse, and the interval that follows must begin with no reference. The next sample of the opposite sign therefore becomes a new reference and does not count as a crossing. Only a later flip may schedule the commutation, and the bench checks the exact cycle count to it.

// File: rtl/bemf_pkg.sv
package bemf_pkg;

    // Converter input facing the unpowered winding
    typedef enum logic [1:0] {
        PH_A = 2'd0,
        PH_B = 2'd1,
        PH_C = 2'd2
    } phase_ch_e;

    // Sign-tracking state of the crossing detector
    typedef struct packed {
        logic have_ref;   // a reference sample exists in this interval
        logic ref_neg;    // sign of that reference
        logic found;      // crossing already taken in this interval
    } zc_state_t;

    // Sector sequence, wraps over six steps in either direction
    function automatic logic [2:0] step_sector(input logic [2:0] s, input logic fwd);
        logic [2:0] r;
        if (s > 3'd5)      r = 3'd0;
        else if (fwd)      r = (s == 3'd5) ? 3'd0 : s + 3'd1;
        else               r = (s == 3'd0) ? 3'd5 : s - 3'd1;
        return r;
    endfunction

    // Unpowered winding for each sector
    function automatic phase_ch_e float_phase(input logic [2:0] s);
        phase_ch_e r;
        case (s)
            3'd0, 3'd3: r = PH_C;
            3'd1, 3'd4: r = PH_B;
            default:    r = PH_A;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/bemf_zc_detect.sv
module bemf_zc_detect
    import bemf_pkg::*;
#(
    parameter int SW          = 12,
    parameter int TW          = 16,
    parameter int DECAY_TICKS = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 smp_valid,
    input  logic signed [SW-1:0] phase_smp,
    input  logic        [SW-1:0] bus_smp,
    input  logic        [TW-1:0] cnt,
    input  logic                 comm,
    output logic                 zc_hit,
    output logic        [TW-1:0] zc_stamp
);

    localparam int            EW      = SW + 2;
    localparam logic [TW-1:0] DECAY_W = TW'(DECAY_TICKS);

    zc_state_t st;

    logic signed [EW-1:0] twice_ph;
    logic signed [EW-1:0] bus_ext;
    logic signed [EW-1:0] bemf2;
    logic                 neg;
    logic                 armed;
    logic                 accept;

    // phase - bus/2 scaled by two keeps the half-bus point exact
    assign twice_ph = $signed({phase_smp[SW-1], phase_smp, 1'b0});
    assign bus_ext  = $signed({2'b00, bus_smp});
    assign bemf2    = twice_ph - bus_ext;
    assign neg      = bemf2[EW-1];

    assign armed    = (cnt >= DECAY_W) && !st.found;
    assign accept   = smp_valid && armed && !comm;
    assign zc_hit   = accept && st.have_ref && (neg != st.ref_neg);
    assign zc_stamp = cnt;

    always_ff @(posedge clk) begin
        if (rst || comm) begin
            st <= '0;
        end else if (accept) begin
            st.have_ref <= 1'b1;
            st.ref_neg  <= neg;
            if (zc_hit) st.found <= 1'b1;
        end
    end

    // R3
    single_hit_chk: assert property (@(posedge clk) disable iff (rst)
        zc_hit |=> !zc_hit);

endmodule

// File: rtl/bemf_comm_timer.sv
module bemf_comm_timer #(
    parameter int TW          = 16,
    parameter int TICK_DIV    = 64,
    parameter int INIT_PERIOD = 1000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          zc_hit,
    input  logic [TW-1:0] zc_stamp,
    output logic          comm,
    output logic          missed,
    output logic [TW-1:0] period,
    output logic [TW-1:0] cnt
);

    localparam int            PW       = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam longint        CMAX     = (longint'(1) << TW) - 1;
    localparam logic [TW:0]   MAXV     = {1'b0, {TW{1'b1}}};
    localparam longint        INIT2    = 2 * longint'(INIT_PERIOD);
    localparam logic [TW-1:0] INIT_W   = TW'(INIT_PERIOD);
    localparam logic [TW-1:0] INIT_MOD = (INIT2 > CMAX) ? {TW{1'b1}} : TW'(INIT2);

    logic          tick;
    logic [TW-1:0] modulo;
    logic          crossed;
    logic [TW-1:0] cnt_nx;
    logic [TW-1:0] half;
    logic [TW:0]   sched_raw;
    logic [TW:0]   dbl_raw;
    logic [TW-1:0] sched;
    logic [TW-1:0] dbl;

    generate
        if (TICK_DIV > 1) begin : g_div
            logic [PW-1:0] pre;
            always_ff @(posedge clk) begin
                if (rst)                            pre <= '0;
                else if (pre == PW'(TICK_DIV - 1))  pre <= '0;
                else                                pre <= pre + 1'b1;
            end
            assign tick = (pre == PW'(TICK_DIV - 1));
        end else begin : g_nodiv
            assign tick = 1'b1;
        end
    endgenerate

    assign cnt_nx    = cnt + 1'b1;
    assign comm      = tick && (cnt_nx >= modulo);
    assign missed    = comm && !crossed;

    assign half      = (period[TW-1:1] == '0) ? TW'(1) : {1'b0, period[TW-1:1]};
    assign sched_raw = {1'b0, zc_stamp} + {1'b0, half};
    assign dbl_raw   = {cnt_nx, 1'b0};
    assign sched     = (sched_raw > MAXV) ? {TW{1'b1}} : sched_raw[TW-1:0];
    assign dbl       = (dbl_raw   > MAXV) ? {TW{1'b1}} : dbl_raw[TW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            modulo  <= INIT_MOD;
            period  <= INIT_W;
            crossed <= 1'b0;
        end else if (comm) begin
            cnt     <= '0;
            period  <= cnt_nx;
            modulo  <= dbl;       // timeout until a crossing reschedules
            crossed <= 1'b0;
        end else begin
            if (tick)   cnt <= cnt_nx;
            if (zc_hit) begin
                modulo  <= sched;
                crossed <= 1'b1;
            end
        end
    end

    // R6
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= modulo);

    // R4
    sched_ahead_chk: assert property (@(posedge clk) disable iff (rst)
        zc_hit |=> modulo > $past(cnt));

endmodule

// File: rtl/bemf_rev_sum.sv
module bemf_rev_sum #(
    parameter int TW          = 16,
    parameter int DEPTH       = 6,
    parameter int INIT_PERIOD = 1000
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               push,
    input  logic [TW-1:0]                      newp,
    output logic [TW+$clog2(DEPTH)-1:0]        sum
);

    localparam int              SUMW     = TW + $clog2(DEPTH);
    localparam logic [TW-1:0]   INIT_W   = TW'(INIT_PERIOD);
    localparam logic [SUMW-1:0] SUM_INIT = SUMW'(DEPTH * INIT_PERIOD);

    logic [TW-1:0] hist [DEPTH];

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_tap
            if (i == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (rst)       hist[i] <= INIT_W;
                    else if (push) hist[i] <= newp;
                end
            end else begin : g_body
                always_ff @(posedge clk) begin
                    if (rst)       hist[i] <= INIT_W;
                    else if (push) hist[i] <= hist[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)       sum <= SUM_INIT;
        else if (push) sum <= sum + SUMW'(newp) - SUMW'(hist[DEPTH-1]);
    end

endmodule

// File: rtl/bemf_comm_sched.sv
module bemf_comm_sched
    import bemf_pkg::*;
#(
    parameter int SW          = 12,
    parameter int TW          = 16,
    parameter int DW          = 12,
    parameter int TICK_DIV    = 64,
    parameter int INIT_PERIOD = 1000,
    parameter int DECAY_TICKS = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 smp_valid,
    input  logic signed [SW-1:0] phase_smp,
    input  logic        [SW-1:0] bus_smp,
    input  logic        [2:0]    sector,
    input  logic                 dir_fwd,
    input  logic        [DW-1:0] duty,
    input  logic        [DW-1:0] dly_min,
    output logic                 comm_pulse,
    output logic        [2:0]    next_sector,
    output logic        [1:0]    adc_sel,
    output logic        [TW-1:0] period_out,
    output logic        [TW+2:0] rev_sum,
    output logic                 missed_zc,
    output logic        [DW-1:0] smp_delay
);

    localparam int REV_STEPS = 6;

    logic          zc_hit;
    logic [TW-1:0] zc_stamp;
    logic [TW-1:0] cnt;
    logic [DW:0]   dbl_duty;
    logic [DW-1:0] frac_duty;

    bemf_comm_timer #(
        .TW(TW), .TICK_DIV(TICK_DIV), .INIT_PERIOD(INIT_PERIOD)
    ) u_timer (
        .clk(clk), .rst(rst), .zc_hit(zc_hit), .zc_stamp(zc_stamp),
        .comm(comm_pulse), .missed(missed_zc), .period(period_out), .cnt(cnt)
    );

    bemf_zc_detect #(
        .SW(SW), .TW(TW), .DECAY_TICKS(DECAY_TICKS)
    ) u_detect (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .phase_smp(phase_smp),
        .bus_smp(bus_smp), .cnt(cnt), .comm(comm_pulse),
        .zc_hit(zc_hit), .zc_stamp(zc_stamp)
    );

    bemf_rev_sum #(
        .TW(TW), .DEPTH(REV_STEPS), .INIT_PERIOD(INIT_PERIOD)
    ) u_rev (
        .clk(clk), .rst(rst), .push(comm_pulse), .newp(cnt + 1'b1), .sum(rev_sum)
    );

    assign next_sector = step_sector(sector, dir_fwd);
    assign adc_sel     = float_phase(sector);

    // two fifths of the duty, floored, then held above the minimum
    assign dbl_duty  = {duty, 1'b0};
    assign frac_duty = DW'(dbl_duty / (DW+1)'(5));
    assign smp_delay = (frac_duty < dly_min) ? dly_min : frac_duty;

    // R5
    missed_on_comm_chk: assert property (@(posedge clk) disable iff (rst)
        missed_zc |-> comm_pulse);

    // R11
    hold_between_chk: assert property (@(posedge clk) disable iff (rst)
        !comm_pulse |=> $stable(period_out) && $stable(rev_sum));

endmodule

// File: tb/bemf_comm_sched_test.sv
module bemf_comm_sched_test;

    localparam int CLK_PERIOD = 10;
    localparam int SW = 12, TW = 16, DW = 12;
    localparam int DIV = 4, INIT = 10, DECAY = 3;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 smp_valid = 1'b0;
    logic signed [SW-1:0] phase_smp = '0;
    logic        [SW-1:0] bus_smp = 12'd1000;
    logic        [2:0]    sector = 3'd0;
    logic                 dir_fwd = 1'b1;
    logic        [DW-1:0] duty = '0;
    logic        [DW-1:0] dly_min = '0;
    logic                 comm_pulse;
    logic        [2:0]    next_sector;
    logic        [1:0]    adc_sel;
    logic        [TW-1:0] period_out;
    logic        [TW+2:0] rev_sum;
    logic                 missed_zc;
    logic        [DW-1:0] smp_delay;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 1'b0;
    int hist_m [6];
    int sum_m;
    int e_prev;
    int e_now;
    int rel;

    bemf_comm_sched #(
        .SW(SW), .TW(TW), .DW(DW), .TICK_DIV(DIV),
        .INIT_PERIOD(INIT), .DECAY_TICKS(DECAY)
    ) uut (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .phase_smp(phase_smp),
        .bus_smp(bus_smp), .sector(sector), .dir_fwd(dir_fwd), .duty(duty),
        .dly_min(dly_min), .comm_pulse(comm_pulse), .next_sector(next_sector),
        .adc_sel(adc_sel), .period_out(period_out), .rev_sum(rev_sum),
        .missed_zc(missed_zc), .smp_delay(smp_delay)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_push(input int p);
        sum_m = sum_m + p - hist_m[5];
        for (int i = 5; i > 0; i--) hist_m[i] = hist_m[i-1];
        hist_m[0] = p;
    endtask

    // returns index of the clock edge that performs the commutation
    task automatic wait_comm(output int e);
        @(negedge clk);
        while (!comm_pulse) @(negedge clk);
        e = cyc + 1;
    endtask

    task automatic drive_at(input int e, input int stamp, input int ph);
        while (cyc < e + DIV*stamp) @(negedge clk);
        smp_valid = 1'b1;
        phase_smp = SW'(ph);
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic after_comm(input string req, input int p);
        @(negedge clk);
        model_push(p);
        chk({req, " period_out"}, period_out, p);
        chk("R11 rev_sum", rev_sum, sum_m);
    endtask

    task automatic t_reset();
        chk("R12 period_out", period_out, INIT);
        chk("R12 rev_sum", rev_sum, 6*INIT);
        chk("R12 comm_pulse", comm_pulse, 0);
        chk("R12 missed_zc", missed_zc, 0);
    endtask

    task automatic t_first_timeout();
        wait_comm(e_now);
        chk("R12 first interval cycles", e_now - rel, DIV*2*INIT);
        chk("R5 missed on timeout", missed_zc, 1);
        after_comm("R6", 2*INIT);
        @(negedge clk);
        chk("R6 pulse one cycle", comm_pulse, 0);
        e_prev = e_now;
    endtask

    task automatic t_window_cross();
        drive_at(e_prev, 1, 300);   // before the decay window: ignored
        drive_at(e_prev, 4, 700);   // reference
        drive_at(e_prev, 7, 300);   // crossing, stamp 7
        drive_at(e_prev, 8, 700);   // after the crossing: ignored
        wait_comm(e_now);
        chk("R4 R2 R3 scheduled interval", e_now - e_prev, DIV*(7 + 10));
        chk("R4 no missed flag", missed_zc, 0);
        after_comm("R4", 17);
        e_prev = e_now;
    endtask

    task automatic t_collision();
        drive_at(e_prev, 4, 700);
        wait_comm(e_now);
        smp_valid = 1'b1;
        phase_smp = SW'(300);
        chk("R7 timeout interval", e_now - e_prev, DIV*34);
        chk("R7 crossing in comm cycle not taken", missed_zc, 1);
        @(negedge clk);
        smp_valid = 1'b0;
        model_push(34);
        chk("R7 period_out", period_out, 34);
        chk("R11 rev_sum", rev_sum, sum_m);
        e_prev = e_now;
    endtask

    task automatic t_fresh_ref();
        drive_at(e_prev, 4, 700);   // new reference, no stale one
        drive_at(e_prev, 6, 300);
        wait_comm(e_now);
        chk("R7 fresh reference interval", e_now - e_prev, DIV*(6 + 17));
        chk("R4 no missed flag", missed_zc, 0);
        after_comm("R4", 23);
        e_prev = e_now;
    endtask

    task automatic t_rising_zero();
        drive_at(e_prev, 4, 200);   // 2*200-1000 < 0
        drive_at(e_prev, 5, 500);   // exactly zero: non-negative
        wait_comm(e_now);
        chk("R1 rising and zero crossing", e_now - e_prev, DIV*(5 + 11));
        after_comm("R1", 16);
        e_prev = e_now;
    endtask

    task automatic t_six_window();
        wait_comm(e_now);
        chk("R5 timeout interval", e_now - e_prev, DIV*32);
        chk("R5 missed flag", missed_zc, 1);
        after_comm("R11", 32);
        e_prev = e_now;
    endtask

    task automatic t_sectors();
        for (int s = 0; s < 6; s++) begin
            sector  = 3'(s);
            dir_fwd = 1'b1;
            #1;
            chk("R8 forward step", next_sector, (s + 1) % 6);
            chk("R9 adc select", adc_sel, (s % 3 == 0) ? 2 : ((s % 3 == 1) ? 1 : 0));
            dir_fwd = 1'b0;
            #1;
            chk("R8 reverse step", next_sector, (s + 5) % 6);
        end
    endtask

    task automatic t_delay();
        duty = 12'd1000; dly_min = 12'd230; #1;
        chk("R10 delay above min", smp_delay, 400);
        duty = 12'd400;  #1;
        chk("R10 delay clamped", smp_delay, 230);
        duty = 12'd1003; dly_min = 12'd0; #1;
        chk("R10 delay floor", smp_delay, 401);
    endtask

    initial begin
        for (int i = 0; i < 6; i++) hist_m[i] = INIT;
        sum_m = 6*INIT;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        rel = cyc;
        t_reset();
        t_first_timeout();
        t_window_cross();
        t_collision();
        t_fresh_ref();
        t_rising_zero();
        t_six_window();
        t_sectors();
        t_delay();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule